// File: doc/BRIEF.md
# I/O Select Command Decoder

This block decodes and carries out the miscellaneous-operation instruction that looks after peripheral units and a bank of per-sequence flags. Each instruction carries a two-bit subcode, a unit number, a configuration field and a 16-bit operand. The leading octal digit of the operand picks the command: disconnect, connect with a 12-bit mode, lower flag or raise flag. Other operand values, and the subcodes that are not implemented or not defined, raise an alarm instead.

The block keeps one flag per unit and a register holding the currently running sequence. Some of the outcome depends on whether the addressed unit is that sequence. The outputs are single-cycle strobes, all registered, one cycle after the instruction is presented. They go to the device models, to the trap circuit, to the store that captures report words, and to the scheduler that acts on dismiss requests. The flag bank changes on the same clock edge as the strobes.

Top module: `iosel_decoder`

## Requirements
- R1: Subcode 01 gives an alarm with code 1, and subcode 10 or 11 gives an alarm with code 0. Both alarms are unmasked, whatever the operand.
- R2: Subcode 00 with operand exactly octal 020000 pulses `disc_stb_o` with `unit_o` equal to the addressed unit.
- R3: Subcode 00 with an operand from octal 030000 to 037777 pulses `conn_stb_o`, with `mode_o` equal to the operand's low 12 bits.
- R4: A connect addressed to unit octal 42 pulses `trap_stb_o` and carries the mode on `mode_o`. It never pulses `conn_stb_o`.
- R5: Operand exactly octal 040000 clears the unit's flag at the output edge. If the unit is the current sequence, `runnable_stb_o` also pulses.
- R6: Operand exactly octal 050000 sets the unit's flag at the output edge. If the unit is the current sequence, any dismiss requested by that instruction is cancelled.
- R7: An operand from octal 060000 to 060777 gives an unmasked alarm with code 2, whatever the mask input.
- R8: Any other subcode-00 operand, including one with bit 15 set, gives an alarm with code 3. This alarm is unmasked only when `ios_mask_i` is low. When masked, the command has no effect, but report and dismiss still go ahead.
- R9: Config bit 0 pulses `report_stb_o`, with `report_o` = {the unit's flag before this instruction, `status_i` sampled with the instruction}.
- R10: Config bit 4 pulses `dismiss_stb_o` unless `hold_i` is high with the instruction.
- R11: Each alarm pulses `alarm_stb_o` for one cycle per instruction. An unmasked alarm also pulses `alarm_halt_o` and suppresses every other strobe and every flag change for that instruction.
- R12: After reset all flags are clear, every strobe is low and no sequence is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_load_i | input | 1 | Load the current-sequence register |
| seq_valid_i | input | 1 | With load: a sequence is running |
| seq_id_i | input | UNIT_W | With load: number of the running sequence |
| instr_valid_i | input | 1 | Instruction present this cycle |
| subcode_i | input | 2 | Operation subcode |
| unit_i | input | UNIT_W | Addressed unit |
| cfg_i | input | CFG_W | Configuration field |
| operand_i | input | 16 | Operand |
| hold_i | input | 1 | Hold active for the current sequence |
| ios_mask_i | input | 1 | Masks the I/O select alarm |
| status_i | input | STAT_W | Status word of the addressed unit |
| unit_o | output | UNIT_W | Unit of the last instruction |
| disc_stb_o | output | 1 | Disconnect strobe |
| conn_stb_o | output | 1 | Device connect strobe |
| trap_stb_o | output | 1 | Trap circuit connect strobe |
| mode_o | output | 12 | Connect mode word |
| runnable_stb_o | output | 1 | Current sequence stays runnable |
| report_stb_o | output | 1 | Report capture strobe |
| report_o | output | STAT_W+1 | Flag and status word |
| dismiss_stb_o | output | 1 | Dismiss request |
| alarm_stb_o | output | 1 | Alarm raised |
| alarm_halt_o | output | 1 | Alarm is unmasked |
| alarm_code_o | output | 2 | Alarm kind |
| flags_o | output | 2**UNIT_W | Flag bank |

## Verification
The bench builds the block with its default parameters: 64 units, the trap unit at octal 42, a 12-bit status word, and report and dismiss at config bits 0 and 4. With these values the whole flag bank can be observed, so every flag write is checked at the ports. Random units are biased towards the current sequence and the trap unit. This brings into reach the cases where lower, raise and dismiss interact with the running sequence, and where a connect is redirected to the trap circuit.

// File: rtl/iosel_pkg.sv
// Package: shared command and alarm types for the I/O select decoder.
// Assumes a 16-bit operand whose bits 14..12 hold the leading octal digit.
package iosel_pkg;
    localparam int OPND_W = 16;
    localparam int MODE_W = 12;

    typedef enum logic [2:0] {
        CMD_DISC   = 3'd0,
        CMD_CONN   = 3'd1,
        CMD_LOWER  = 3'd2,
        CMD_RAISE  = 3'd3,
        CMD_SELECT = 3'd4,
        CMD_BADIOS = 3'd5,
        CMD_AUX    = 3'd6,
        CMD_UNDEF  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ALM_OPCODE = 2'd0,
        ALM_AUX    = 2'd1,
        ALM_SELECT = 2'd2,
        ALM_IOS    = 2'd3
    } alarm_e;
endpackage

// File: rtl/iosel_cmd_decode.sv
// Module: iosel_cmd_decode
// Classifies subcode and operand into one command. Purely combinational.
// Assumes operand bit 15 is a modifier bit; a set bit 15 never matches a command.
module iosel_cmd_decode
    import iosel_pkg::*;
(
    input  logic [1:0]        subcode_i,
    input  logic [OPND_W-1:0] operand_i,
    output cmd_e              cmd_o
);
    logic [2:0] lead_dig;
    logic       top_bit;

    assign lead_dig = operand_i[14:12];
    assign top_bit  = operand_i[15];

    // Pick the command from subcode first, then operand value.
    always_comb begin
        if (subcode_i[1])
            cmd_o = CMD_UNDEF;
        else if (subcode_i[0])
            cmd_o = CMD_AUX;
        else if (operand_i == 16'o020000)
            cmd_o = CMD_DISC;
        else if (!top_bit && lead_dig == 3'd3)
            cmd_o = CMD_CONN;
        else if (operand_i == 16'o040000)
            cmd_o = CMD_LOWER;
        else if (operand_i == 16'o050000)
            cmd_o = CMD_RAISE;
        else if (!top_bit && lead_dig == 3'd6 && operand_i[11:9] == 3'd0)
            cmd_o = CMD_SELECT;
        else
            cmd_o = CMD_BADIOS;
    end
endmodule

// File: rtl/iosel_flag_bank.sv
// Module: iosel_flag_bank
// One flag per unit; raise/lower by index, combinational read of the old value.
// Assumes raise and lower are never requested in the same cycle.
module iosel_flag_bank #(
    parameter int UNIT_W = 6,
    localparam int NUM_UNITS = 1 << UNIT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 raise_en_i,
    input  logic                 lower_en_i,
    input  logic [UNIT_W-1:0]    idx_i,
    output logic                 rd_flag_o,
    output logic [NUM_UNITS-1:0] flags_o
);
    logic [NUM_UNITS-1:0] flags_q;

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_flag
        // Update one flag bit when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[g] <= 1'b0;
            else if (idx_i == UNIT_W'(g) && raise_en_i)
                flags_q[g] <= 1'b1;
            else if (idx_i == UNIT_W'(g) && lower_en_i)
                flags_q[g] <= 1'b0;
        end
    end

    assign rd_flag_o = flags_q[idx_i];
    assign flags_o   = flags_q;

    a_r6_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        raise_en_i |=> flags_q[$past(idx_i)]);
    a_r5_lower_clears: assert property (@(posedge clk) disable iff (!rst_n)
        lower_en_i |=> !flags_q[$past(idx_i)]);
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(raise_en_i || lower_en_i) |=> $stable(flags_q));
endmodule

// File: rtl/iosel_seq_reg.sv
// Module: iosel_seq_reg
// Holds the current-sequence number and tells whether a unit matches it.
// Assumes no sequence is current after reset.
module iosel_seq_reg #(
    parameter int UNIT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              valid_i,
    input  logic [UNIT_W-1:0] id_i,
    input  logic [UNIT_W-1:0] probe_i,
    output logic              match_o
);
    logic              valid_q;
    logic [UNIT_W-1:0] id_q;

    // Capture the running sequence on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            id_q    <= '0;
        end else if (load_i) begin
            valid_q <= valid_i;
            id_q    <= id_i;
        end
    end

    assign match_o = valid_q && (id_q == probe_i);
endmodule

// File: rtl/iosel_decoder.sv
// Module: iosel_decoder (top)
// Executes the I/O select instruction: unit connect/disconnect, flag raise/lower,
// report capture and dismiss, with alarms for unsupported encodings.
// Assumes one instruction per instr_valid cycle; all outputs appear one cycle later.
module iosel_decoder
    import iosel_pkg::*;
#(
    parameter int UNIT_W          = 6,
    parameter int STAT_W          = 12,
    parameter int CFG_W           = 6,
    parameter int TRAP_UNIT       = 34,
    parameter int CFG_REPORT_BIT  = 0,
    parameter int CFG_DISMISS_BIT = 4,
    localparam int NUM_UNITS = 1 << UNIT_W,
    localparam int REP_W     = STAT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 seq_load_i,
    input  logic                 seq_valid_i,
    input  logic [UNIT_W-1:0]    seq_id_i,
    input  logic                 instr_valid_i,
    input  logic [1:0]           subcode_i,
    input  logic [UNIT_W-1:0]    unit_i,
    input  logic [CFG_W-1:0]     cfg_i,
    input  logic [15:0]          operand_i,
    input  logic                 hold_i,
    input  logic                 ios_mask_i,
    input  logic [STAT_W-1:0]    status_i,
    output logic [UNIT_W-1:0]    unit_o,
    output logic                 disc_stb_o,
    output logic                 conn_stb_o,
    output logic                 trap_stb_o,
    output logic [11:0]          mode_o,
    output logic                 runnable_stb_o,
    output logic                 report_stb_o,
    output logic [REP_W-1:0]     report_o,
    output logic                 dismiss_stb_o,
    output logic                 alarm_stb_o,
    output logic                 alarm_halt_o,
    output logic [1:0]           alarm_code_o,
    output logic [NUM_UNITS-1:0] flags_o
);
    cmd_e   cmd;
    logic   is_cur, old_flag;
    logic   any_alarm, halt_alarm, ok;
    logic   do_disc, do_conn, do_trap, do_lower, do_raise, do_run, do_rep, do_dis;
    alarm_e alarm_kind;

    iosel_cmd_decode u_dec (
        .subcode_i (subcode_i),
        .operand_i (operand_i),
        .cmd_o     (cmd)
    );

    iosel_seq_reg #(.UNIT_W(UNIT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (seq_load_i),
        .valid_i (seq_valid_i),
        .id_i    (seq_id_i),
        .probe_i (unit_i),
        .match_o (is_cur)
    );

    iosel_flag_bank #(.UNIT_W(UNIT_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_en_i (do_raise),
        .lower_en_i (do_lower),
        .idx_i      (unit_i),
        .rd_flag_o  (old_flag),
        .flags_o    (flags_o)
    );

    // Map the command to alarm presence, severity and kind.
    always_comb begin
        any_alarm  = 1'b1;
        halt_alarm = 1'b1;
        alarm_kind = ALM_IOS;
        unique case (cmd)
            CMD_UNDEF:  alarm_kind = ALM_OPCODE;
            CMD_AUX:    alarm_kind = ALM_AUX;
            CMD_SELECT: alarm_kind = ALM_SELECT;
            CMD_BADIOS: begin
                alarm_kind = ALM_IOS;
                halt_alarm = !ios_mask_i;
            end
            default: begin
                any_alarm  = 1'b0;
                halt_alarm = 1'b0;
            end
        endcase
    end

    // Qualify every action by a valid instruction without an unmasked alarm.
    always_comb begin
        ok       = instr_valid_i && !halt_alarm;
        do_disc  = ok && cmd == CMD_DISC;
        do_conn  = ok && cmd == CMD_CONN && unit_i != UNIT_W'(TRAP_UNIT);
        do_trap  = ok && cmd == CMD_CONN && unit_i == UNIT_W'(TRAP_UNIT);
        do_lower = ok && cmd == CMD_LOWER;
        do_raise = ok && cmd == CMD_RAISE;
        do_run   = do_lower && is_cur;
        do_rep   = ok && cfg_i[CFG_REPORT_BIT];
        do_dis   = ok && cfg_i[CFG_DISMISS_BIT] && !hold_i && !(do_raise && is_cur);
    end

    logic unused_cfg;
    assign unused_cfg = ^cfg_i;

    // Register the strobes so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disc_stb_o     <= 1'b0;
            conn_stb_o     <= 1'b0;
            trap_stb_o     <= 1'b0;
            runnable_stb_o <= 1'b0;
            report_stb_o   <= 1'b0;
            dismiss_stb_o  <= 1'b0;
            alarm_stb_o    <= 1'b0;
            alarm_halt_o   <= 1'b0;
        end else begin
            disc_stb_o     <= do_disc;
            conn_stb_o     <= do_conn;
            trap_stb_o     <= do_trap;
            runnable_stb_o <= do_run;
            report_stb_o   <= do_rep;
            dismiss_stb_o  <= do_dis;
            alarm_stb_o    <= instr_valid_i && any_alarm;
            alarm_halt_o   <= instr_valid_i && halt_alarm;
        end
    end

    // Register the data fields that go with an instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_o       <= '0;
            mode_o       <= '0;
            report_o     <= '0;
            alarm_code_o <= '0;
        end else if (instr_valid_i) begin
            unit_o       <= unit_i;
            mode_o       <= operand_i[MODE_W-1:0];
            report_o     <= {old_flag, status_i};
            alarm_code_o <= alarm_kind;
        end
    end

    a_r11_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_halt_o |-> !(disc_stb_o || conn_stb_o || trap_stb_o || runnable_stb_o
                           || report_stb_o || dismiss_stb_o));
    a_r11_halt_is_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_halt_o |-> alarm_stb_o);
    a_r4_trap_not_device: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_stb_o && conn_stb_o));
    a_r2_disc_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
        disc_stb_o |-> $past(instr_valid_i));
    a_r10_no_dismiss_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dismiss_stb_o |-> !$past(hold_i));
    a_r5_runnable_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        runnable_stb_o |-> !flags_o[unit_o]);
endmodule

// File: tb/iosel_decoder_tb_top.sv
module iosel_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seq_load_i = 1'b0, seq_valid_i = 1'b0;
    logic [5:0]  seq_id_i = '0;
    logic        instr_valid_i = 1'b0;
    logic [1:0]  subcode_i = '0;
    logic [5:0]  unit_i = '0;
    logic [5:0]  cfg_i = '0;
    logic [15:0] operand_i = '0;
    logic        hold_i = 1'b0, ios_mask_i = 1'b0;
    logic [11:0] status_i = '0;
    logic [5:0]  unit_o;
    logic        disc_stb_o, conn_stb_o, trap_stb_o, runnable_stb_o;
    logic        report_stb_o, dismiss_stb_o, alarm_stb_o, alarm_halt_o;
    logic [11:0] mode_o;
    logic [12:0] report_o;
    logic [1:0]  alarm_code_o;
    logic [63:0] flags_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] m_flags = '0;
    logic        m_seq_valid = 1'b0;
    logic [5:0]  m_seq_id = '0;

    always #2.5 clk = ~clk;

    iosel_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .seq_load_i(seq_load_i), .seq_valid_i(seq_valid_i),
        .seq_id_i(seq_id_i), .instr_valid_i(instr_valid_i), .subcode_i(subcode_i),
        .unit_i(unit_i), .cfg_i(cfg_i), .operand_i(operand_i), .hold_i(hold_i),
        .ios_mask_i(ios_mask_i), .status_i(status_i), .unit_o(unit_o),
        .disc_stb_o(disc_stb_o), .conn_stb_o(conn_stb_o), .trap_stb_o(trap_stb_o),
        .mode_o(mode_o), .runnable_stb_o(runnable_stb_o), .report_stb_o(report_stb_o),
        .report_o(report_o), .dismiss_stb_o(dismiss_stb_o), .alarm_stb_o(alarm_stb_o),
        .alarm_halt_o(alarm_halt_o), .alarm_code_o(alarm_code_o), .flags_o(flags_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // 0 disc,1 conn,2 lower,3 raise,4 select,5 bad,6 aux,7 undef
    function automatic int classify(input logic [1:0] sc, input logic [15:0] op);
        if (sc[1]) return 7;
        if (sc[0]) return 6;
        if (op == 16'o020000) return 0;
        if (op >= 16'o030000 && op <= 16'o037777) return 1;
        if (op == 16'o040000) return 2;
        if (op == 16'o050000) return 3;
        if (op >= 16'o060000 && op <= 16'o060777) return 4;
        return 5;
    endfunction

    function automatic string req_of(input int k, input logic [5:0] u);
        case (k)
            0: return "R2";
            1: return (u == 6'o42) ? "R4" : "R3";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic load_seq(input logic v, input logic [5:0] id);
        @(negedge clk);
        seq_load_i = 1'b1; seq_valid_i = v; seq_id_i = id;
        @(posedge clk); #1;
        seq_load_i = 1'b0;
        m_seq_valid = v; m_seq_id = id;
    endtask

    task automatic issue(input logic [1:0] sc, input logic [5:0] u, input logic [5:0] cf,
                         input logic [15:0] op, input logic hold, input logic mask,
                         input logic [11:0] st, input string tag);
        int k;
        logic cur, halt, alarm, ok;
        logic [7:0] e_vec, a_vec;
        logic [1:0] e_code;
        logic [12:0] e_rep;
        string req;
        k = classify(sc, op);
        req = (tag == "") ? req_of(k, u) : tag;
        cur = m_seq_valid && m_seq_id == u;
        alarm = (k >= 4);
        halt = (k == 4 || k == 6 || k == 7 || (k == 5 && !mask));
        ok = !halt;
        e_code = (k == 7) ? 2'd0 : (k == 6) ? 2'd1 : (k == 4) ? 2'd2 : 2'd3;
        e_rep = {m_flags[u], st};
        e_vec = {ok && k == 0, ok && k == 1 && u != 6'o42, ok && k == 1 && u == 6'o42,
                 ok && k == 2 && cur, ok && cf[0],
                 ok && cf[4] && !hold && !(k == 3 && cur), alarm, halt};
        if (ok && k == 2) m_flags[u] = 1'b0;
        if (ok && k == 3) m_flags[u] = 1'b1;
        @(negedge clk);
        instr_valid_i = 1'b1; subcode_i = sc; unit_i = u; cfg_i = cf; operand_i = op;
        hold_i = hold; ios_mask_i = mask; status_i = st;
        @(posedge clk); #1;
        instr_valid_i = 1'b0;
        a_vec = {disc_stb_o, conn_stb_o, trap_stb_o, runnable_stb_o, report_stb_o,
                 dismiss_stb_o, alarm_stb_o, alarm_halt_o};
        chk(req, "strobes", 64'(a_vec), 64'(e_vec));
        if (alarm) chk(req, "alarm code", 64'(alarm_code_o), 64'(e_code));
        if (e_vec[6] || e_vec[5]) chk(req, "mode", 64'(mode_o), 64'(op[11:0]));
        if (e_vec[7] || e_vec[6]) chk(req, "unit", 64'(unit_o), 64'(u));
        if (e_vec[3]) chk("R9", "report word", 64'(report_o), 64'(e_rep));
        chk(req, "flags", flags_o, m_flags);
        // R11: strobes drop after one cycle
        @(posedge clk); #1;
        chk("R11", "pulse width", 64'({disc_stb_o, conn_stb_o, trap_stb_o, alarm_stb_o,
                                      report_stb_o, dismiss_stb_o}), 64'(0));
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        chk("R12", "reset flags", flags_o, 64'(0));
        chk("R12", "reset strobes", 64'({disc_stb_o, conn_stb_o, trap_stb_o, alarm_stb_o,
                                        report_stb_o, dismiss_stb_o}), 64'(0));
        @(negedge clk); rst_n = 1'b1;
        // R12: no sequence current, so lowering unit 0 is not runnable
        issue(2'b00, 6'd0, 6'd0, 16'o040000, 0, 0, 12'h0, "R12");
        // R1
        issue(2'b01, 6'd5, 6'o21, 16'o020000, 0, 0, 12'h1, "R1");
        issue(2'b10, 6'd5, 6'o21, 16'o050000, 0, 1, 12'h1, "R1");
        issue(2'b11, 6'd5, 6'o00, 16'o030001, 0, 0, 12'h1, "R1");
        // R2, R3, R4
        issue(2'b00, 6'd7, 6'd0, 16'o020000, 0, 0, 12'h0, "R2");
        issue(2'b00, 6'd8, 6'd0, 16'o037777, 0, 0, 12'h0, "R3");
        issue(2'b00, 6'd8, 6'd0, 16'o030000, 0, 0, 12'h0, "R3");
        issue(2'b00, 6'o42, 6'd0, 16'o031234, 0, 0, 12'h0, "R4");
        // R6 then R9: raise then report sees the old flag
        issue(2'b00, 6'd9, 6'd0, 16'o050000, 0, 0, 12'h0, "R6");
        issue(2'b00, 6'd9, 6'd1, 16'o040000, 0, 0, 12'hABC, "R9");
        issue(2'b00, 6'd9, 6'd1, 16'o020000, 0, 0, 12'h123, "R9");
        // R5 / R6 against the current sequence
        load_seq(1'b1, 6'd12);
        issue(2'b00, 6'd12, 6'o20, 16'o050000, 0, 0, 12'h0, "R6");
        issue(2'b00, 6'd13, 6'o20, 16'o050000, 0, 0, 12'h0, "R6");
        issue(2'b00, 6'd12, 6'd0, 16'o040000, 0, 0, 12'h0, "R5");
        // R10
        issue(2'b00, 6'd3, 6'o20, 16'o020000, 1, 0, 12'h0, "R10");
        issue(2'b00, 6'd3, 6'o20, 16'o020000, 0, 0, 12'h0, "R10");
        // R7 at both range ends, masked and not
        issue(2'b00, 6'd4, 6'o21, 16'o060000, 0, 1, 12'h0, "R7");
        issue(2'b00, 6'd4, 6'o21, 16'o060777, 0, 0, 12'h0, "R7");
        // R8 / R11: just outside ranges, defer bit, masked vs unmasked
        issue(2'b00, 6'd4, 6'o21, 16'o061000, 0, 0, 12'h0, "R11");
        issue(2'b00, 6'd4, 6'o21, 16'o020001, 0, 1, 12'h5, "R8");
        issue(2'b00, 6'd9, 6'o21, 16'o150000, 0, 1, 12'h6, "R8");
        issue(2'b00, 6'd4, 6'o00, 16'o130000, 0, 0, 12'h0, "R8");
        issue(2'b00, 6'd4, 6'o00, 16'o070000, 0, 1, 12'h0, "R8");
        // Seeded random mix
        void'($urandom(32'd4242));
        for (int n = 0; n < 800; n++) begin
            logic [1:0] sc; logic [5:0] u; logic [15:0] op; int pick;
            if (n % 100 == 50) load_seq($urandom_range(0, 3) != 0, 6'($urandom_range(0, 63)));
            sc = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            pick = $urandom_range(0, 3);
            u = (pick == 0) ? m_seq_id : (pick == 1) ? 6'o42 : 6'($urandom_range(0, 63));
            case ($urandom_range(0, 6))
                0: op = 16'o020000;
                1: op = 16'o030000 | 16'($urandom_range(0, 4095));
                2: op = 16'o040000;
                3: op = 16'o050000;
                4: op = 16'o060000 | 16'($urandom_range(0, 511));
                default: op = 16'($urandom_range(0, 65535));
            endcase
            issue(sc, u, 6'($urandom_range(0, 63)), op, 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 12'($urandom_range(0, 4095)), "");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule